// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This unit compares two IEEE-754 double-precision operands in a single cycle and returns a four-bit condition code with exactly one bit set: less, greater, equal or unordered. It also raises two invalid-operation flags. One flag marks a signalling NaN among the operands. The other marks an invalid compare, and it depends on the selected compare mode.

A caller presents both operands, a mode select (ordered or unordered compare) and an invalid-exception enable, and then pulses the input strobe. The result is registered. It appears one clock later with a one-cycle output valid and stays on the outputs until the next strobe.

Internally a thin top joins a control module, which owns the valid pipeline and issues a load strobe, to a datapath module. The datapath classifies each operand and resolves the ordering. It ranks operands by class before it compares magnitudes.

Top module: `fcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, mantissa nonzero), the code is unordered and no other code bit is set.
- R2: A NaN whose mantissa bit 51 is clear is signalling, and one with bit 51 set is quiet. If either operand is a signalling NaN, `flagSnan` is 1 together with unordered. Otherwise it is 0.
- R3: In ordered mode (`orderedMode`=1) with a NaN present, `flagInvCmp` is 1 when `invalidEn` is 1 or when either operand is a quiet NaN. Otherwise it is 0.
- R4: In unordered mode (`orderedMode`=0), `flagInvCmp` is always 0. Both flags are 0 whenever neither operand is a NaN.
- R5: Two zeros compare equal whatever their signs.
- R6: When the signs differ and the operands are not both zero, a negative `opA` gives less and a positive `opA` gives greater.
- R7: With equal signs, the operands are ranked by class, zero below finite below infinity. A lower class for `opA` gives less when both are positive and greater when both are negative. A higher class gives the mirror result.
- R8: Two infinities of the same sign compare equal.
- R9: Two finite nonzero operands of equal sign, subnormals included, are ordered by exact magnitude on the exponent and mantissa fields. Equal magnitudes give equal, and the result is inverted when both operands are negative.
- R10: After reset, `outValid`, `ccOut` and both flags are 0. Each `inValid` pulse yields the result and a `outValid` pulse on the next clock edge. Without `inValid`, `outValid` is 0 and the result outputs hold their values.
- R11: `ccOut` is one-hot after every result: bit 0 less, bit 1 greater, bit 2 equal, bit 3 unordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| opA | input | 64 | First operand, double precision |
| opB | input | 64 | Second operand, double precision |
| orderedMode | input | 1 | 1 selects an ordered compare, 0 an unordered compare |
| invalidEn | input | 1 | Invalid-exception enable |
| outValid | output | 1 | Result registered this cycle |
| ccOut | output | 4 | One-hot code: less, greater, equal, unordered |
| flagSnan | output | 1 | Signalling-NaN invalid flag |
| flagInvCmp | output | 1 | Invalid-compare flag |

## Verification
The bench targets signed zeros. A design that checked signs first would call +0 greater than -0. It pairs negative operands of different classes and negative finite values, where a missing inversion yields greater instead of less. It walks every mix of NaN kind, mode and enable, because a flag rule wired the obvious way raises the invalid-compare flag for a signalling NaN with the enable clear, or in unordered mode. Subnormal against zero and adjacent subnormals catch a design that treats small values as zero, and a gap of idle cycles catches results that fail to hold.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CC_W      = 4;
  localparam int IDX_LESS  = 0;
  localparam int IDX_GREAT = 1;
  localparam int IDX_EQUAL = 2;
  localparam int IDX_UNORD = 3;

  localparam logic [CC_W-1:0] CC_LESS  = 4'b0001;
  localparam logic [CC_W-1:0] CC_GREAT = 4'b0010;
  localparam logic [CC_W-1:0] CC_EQUAL = 4'b0100;
  localparam logic [CC_W-1:0] CC_UNORD = 4'b1000;

  typedef enum logic [1:0] {
    CLS_ZERO   = 2'd0,
    CLS_FINITE = 2'd1,
    CLS_INF    = 2'd2
  } fcmpClass_t;

  typedef struct packed {
    logic load;
  } fcmpStrobe_t;
endpackage

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output fcmpStrobe_t strobe,
  output logic        outValid
);
  assign strobe.load = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R10
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fcmpStrobe_t              strobe,
  input  logic [EXP_W+MAN_W:0]     opA,
  input  logic [EXP_W+MAN_W:0]     opB,
  input  logic                     orderedMode,
  input  logic                     invalidEn,
  output logic [CC_W-1:0]          ccOut,
  output logic                     flagSnan,
  output logic                     flagInvCmp
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int MAG_W = W - 1;
  localparam int QBIT  = MAN_W - 1;

  logic [W-1:0]     ops   [2];
  logic [MAG_W-1:0] mag   [2];
  fcmpClass_t       cls   [2];
  logic [1:0]       sgn, isNan, isSnan, isQnan, isZero, isInf;

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : gClassify
    logic expAllOnes, manNonZero;
    assign expAllOnes = &ops[i][W-2:MAN_W];
    assign manNonZero = |ops[i][MAN_W-1:0];
    assign sgn[i]     = ops[i][W-1];
    assign mag[i]     = ops[i][MAG_W-1:0];
    assign isNan[i]   = expAllOnes & manNonZero;
    assign isQnan[i]  = isNan[i] & ops[i][QBIT];
    assign isSnan[i]  = isNan[i] & ~ops[i][QBIT];
    assign isInf[i]   = expAllOnes & ~manNonZero;
    assign isZero[i]  = ~|ops[i][MAG_W-1:0];
    assign cls[i]     = isZero[i] ? CLS_ZERO : (isInf[i] ? CLS_INF : CLS_FINITE);
  end

  logic [CC_W-1:0] nextCc;
  logic            nextSnan, nextInv;

  // Resolve an ordering found on magnitude or class; negative pairs flip it.
  function automatic logic [CC_W-1:0] orient(input logic aBelow, input logic neg);
    return (aBelow ^ neg) ? CC_LESS : CC_GREAT;
  endfunction

  always_comb begin
    nextCc   = CC_EQUAL;
    nextSnan = 1'b0;
    nextInv  = 1'b0;
    if (|isNan) begin
      nextCc   = CC_UNORD;
      nextSnan = |isSnan;
      nextInv  = orderedMode & (invalidEn | (|isQnan));
    end else if (&isZero) begin
      nextCc = CC_EQUAL;
    end else if (sgn[0] != sgn[1]) begin
      nextCc = sgn[0] ? CC_LESS : CC_GREAT;
    end else if (cls[0] != cls[1]) begin
      nextCc = orient(cls[0] < cls[1], sgn[0]);
    end else if (isInf[0]) begin
      nextCc = CC_EQUAL;
    end else if (mag[0] == mag[1]) begin
      nextCc = CC_EQUAL;
    end else begin
      nextCc = orient(mag[0] < mag[1], sgn[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccOut      <= '0;
      flagSnan   <= 1'b0;
      flagInvCmp <= 1'b0;
    end else if (strobe.load) begin
      ccOut      <= nextCc;
      flagSnan   <= nextSnan;
      flagInvCmp <= nextInv;
    end
  end

  AST_CC_ONE_HOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> $countones(ccOut) == 1); // R11
  AST_SNAN_UNORD: assert property (@(posedge clk) disable iff (!rstN)
    flagSnan |-> ccOut == CC_UNORD); // R2
  AST_INV_UNORD: assert property (@(posedge clk) disable iff (!rstN)
    flagInvCmp |-> ccOut[IDX_UNORD]); // R3
  AST_UNORD_MODE_NO_INV: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !orderedMode) |=> !flagInvCmp); // R4
  AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && ~|opA[W-2:0] && ~|opB[W-2:0]) |=> ccOut[IDX_EQUAL]); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(ccOut) && $stable(flagSnan) && $stable(flagInvCmp))); // R10
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic                 orderedMode,
  input  logic                 invalidEn,
  output logic                 outValid,
  output logic [3:0]           ccOut,
  output logic                 flagSnan,
  output logic                 flagInvCmp
);
  fcmpStrobe_t strobe;

  fcmp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fcmp_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opA         (opA),
    .opB         (opB),
    .orderedMode (orderedMode),
    .invalidEn   (invalidEn),
    .ccOut       (ccOut),
    .flagSnan    (flagSnan),
    .flagInvCmp  (flagInvCmp)
  );
endmodule

// File: tb/tb_fcmp_unit.sv
module tb_fcmp_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        orderedMode = 1'b0, invalidEn = 1'b0;
  logic        outValid;
  logic [3:0]  ccOut;
  logic        flagSnan, flagInvCmp;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fcmp_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .orderedMode(orderedMode), .invalidEn(invalidEn), .outValid(outValid),
    .ccOut(ccOut), .flagSnan(flagSnan), .flagInvCmp(flagInvCmp)
  );

  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN   = 64'hFFF0_0000_0000_0003;
  localparam logic [63:0] P_SUB1 = 64'h0000_0000_0000_0001;
  localparam logic [63:0] P_SUB2 = 64'h0000_0000_0000_0002;
  localparam logic [63:0] N_SUB1 = 64'h8000_0000_0000_0001;

  typedef struct {
    logic [3:0] cc;
    logic       snan;
    logic       inv;
    string      req;
  } item_t;

  item_t sb[$];

  // Independent model: NaN rules, else map each value onto a signed integer line.
  function automatic item_t model(logic [63:0] a, logic [63:0] b, logic ord, logic en, string req);
    item_t it;
    logic aNan, bNan, aQ, bQ;
    logic signed [64:0] ka, kb;
    aNan = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    bNan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    aQ = aNan && a[51];
    bQ = bNan && b[51];
    it.req = req;
    it.snan = 1'b0;
    it.inv = 1'b0;
    if (aNan || bNan) begin
      it.cc = 4'b1000;
      it.snan = (aNan && !aQ) || (bNan && !bQ);
      it.inv = ord && (en || aQ || bQ);
    end else begin
      ka = a[63] ? -$signed({2'b00, a[62:0]}) : $signed({2'b00, a[62:0]});
      kb = b[63] ? -$signed({2'b00, b[62:0]}) : $signed({2'b00, b[62:0]});
      it.cc = (ka < kb) ? 4'b0001 : (ka > kb) ? 4'b0010 : 4'b0100;
    end
    return it;
  endfunction

  task automatic drive(logic [63:0] a, logic [63:0] b, logic ord, logic en, string req);
    opA = a; opB = b; orderedMode = ord; invalidEn = en; inValid = 1'b1;
    sb.push_back(model(a, b, ord, en, req));
    @(negedge clk);
    inValid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      item_t exp;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected outValid actual=1 expected=0");
      end else begin
        exp = sb.pop_front();
        if (ccOut !== exp.cc || flagSnan !== exp.snan || flagInvCmp !== exp.inv) begin
          errors++;
          $display("FAIL %s actual cc=%b snan=%b inv=%b expected cc=%b snan=%b inv=%b",
                   exp.req, ccOut, flagSnan, flagInvCmp, exp.cc, exp.snan, exp.inv);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [3:0] heldCc;
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || ccOut !== 4'b0 || flagSnan !== 1'b0 || flagInvCmp !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset actual=%b%b%b%b expected=0 0000 0 0", outValid, ccOut, flagSnan, flagInvCmp);
    end
    rstN = 1'b1;
    @(negedge clk);

    drive(P_ONE,  P_TWO,  1, 0, "R9 pos lt");
    drive(P_TWO,  P_ONE,  0, 0, "R9 pos gt");
    drive(N_ONE,  N_TWO,  1, 0, "R9 neg inverted");
    drive(N_TWO,  N_ONE,  0, 1, "R9 neg inverted lt");
    drive(P_ONE,  P_ONE,  1, 1, "R9 equal");
    drive(P_SUB1, P_SUB2, 1, 0, "R9 subnormals");
    drive(P_ZERO, N_ZERO, 1, 0, "R5 signed zeros");
    drive(N_ZERO, P_ZERO, 0, 0, "R5 signed zeros swapped");
    drive(N_ONE,  P_ONE,  1, 0, "R6 neg vs pos");
    drive(P_ONE,  N_INF,  1, 0, "R6 pos vs neg inf");
    drive(N_ZERO, P_SUB1, 1, 0, "R6 neg zero vs pos sub");
    drive(P_ZERO, P_SUB1, 1, 0, "R7 zero below sub");
    drive(N_SUB1, N_ZERO, 1, 0, "R7 neg class mirrored");
    drive(P_ONE,  P_INF,  1, 0, "R7 finite below inf");
    drive(N_INF,  N_ONE,  1, 0, "R7 neg inf lt");
    drive(P_INF,  P_INF,  1, 0, "R8 pos infs");
    drive(N_INF,  N_INF,  0, 0, "R8 neg infs");
    drive(QNAN,   P_ONE,  0, 0, "R1 qnan unordered");
    drive(P_INF,  QNAN,   1, 0, "R3 ordered qnan");
    drive(SNAN,   P_ONE,  1, 0, "R2 R3 ordered snan no enable");
    drive(P_ONE,  SNAN,   1, 1, "R3 ordered snan enabled");
    drive(SNAN,   QNAN,   1, 0, "R2 R3 snan and qnan");
    drive(SNAN,   P_ZERO, 0, 1, "R4 unordered snan enabled");
    drive(QNAN,   QNAN,   0, 1, "R4 unordered qnan enabled");
    drive(P_TWO,  N_ONE,  1, 1, "R4 R11 no flags for numbers");

    heldCc = ccOut;
    opA = QNAN; opB = SNAN; orderedMode = 1'b1; invalidEn = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || ccOut !== 4'b0010 || flagSnan !== 1'b0 || flagInvCmp !== 1'b0) begin
      errors++;
      $display("FAIL R10 hold actual=%b %b %b %b expected=0 0010 0 0 (was %b)",
               outValid, ccOut, flagSnan, flagInvCmp, heldCc);
    end
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10 missing results actual=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule